// File: doc/BRIEF.md
# E1 Receive Frame Aligner

This block takes a serial 2.048 Mbit/s E1 line, already decoded to NRZ and presented one bit per `bit_en` strobe in the system clock domain. It looks for the 256-bit frame structure of 32 eight-bit slots and locks onto it. It then tracks bit position, slot number and which of the two alternating slot-0 contents (alignment word or service word) is due. Once locked, it delivers payload bytes with a one-cycle valid strobe and the slot index. It also extracts the remote alarm indications and the national spare bits from each accepted service word.

Two mode inputs steer it. `mode_unstruct` chooses between the structured payload map, which skips slot 0 and signalling slot 16, and the unstructured map, which carries every slot. `mode_crc4` chooses how the first bit of the alignment word is treated. In double-frame mode that bit is an international user bit and is reported. In CRC4-multiframe mode it is a check bit, so it is not reported. In both modes it is ignored when matching the alignment word. CRC checking, line decoding and clock recovery belong to neighbouring blocks.

Top module: `e1_rx_aligner`

## Requirements
- R1: After synchronous reset, `locked`, `byte_vld`, `rem_urgent`, `rem_minor`, `nat_bits`, `svc_x` and `fas_x` are all 0.
- R2: While searching, a candidate starts at any bit where the last seven received bits are 0011011. These are bits 2–8 of a slot, with bit 1 sent first and ignored. The candidate locks only if the slot-0 byte one frame later has bit 2 = 1 and the slot-0 byte two frames later again carries the alignment pattern. `locked` rises in the clock cycle after the last bit of that third slot 0.
- R3: If the service check of a candidate fails (bit 2 = 0), the candidate is dropped. The search resumes from the following bit, and no lock results from it.
- R4: While locked, loss of lock is declared on the third consecutive errored alignment word. A correct alignment word resets the error run. Two errored words in a row, or errors broken by a correct word, keep lock.
- R5: In structured mode (`mode_unstruct`=0), each locked frame delivers the bytes of slots 1–15 and 17–31 in order. Each byte is delivered with its slot index on `slot_idx`. The first received bit of a slot is bit 7 of `byte_out`. `byte_vld` pulses one clock after the `bit_en` cycle that carries the slot's eighth bit.
- R6: In unstructured mode (`mode_unstruct`=1), all 32 slots, including 0 and 16, are delivered with their indices. This includes slot 0 of the frame in which lock is declared, but not slot 0 of the frame in which lock is lost.
- R7: `byte_vld` never pulses while the block is not locked. From the frame in which lock is lost, no further byte is delivered until lock is regained.
- R8: When a service word is accepted (bit 2 = 1, either in the lock check or while locked), its bit 1 goes to `svc_x`, bit 3 to `rem_urgent`, bit 4 to `rem_minor` and bits 5–8 to `nat_bits[3:0]`, with bit 5 as MSB. These outputs hold between accepted service words; a service word with bit 2 = 0 leaves them unchanged.
- R9: On each accepted alignment word, `fas_x` takes bit 1 of that word in double-frame mode (`mode_crc4`=0) and is cleared to 0 in CRC4 mode (`mode_crc4`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` for one clock per line bit |
| bit_in | input | 1 | Serial line data, first bit of each slot first |
| mode_unstruct | input | 1 | 1: all 32 slots are payload; 0: slots 0 and 16 skipped |
| mode_crc4 | input | 1 | 1: CRC4-multiframe handling of alignment bit 1; 0: double-frame |
| locked | output | 1 | Frame lock status |
| byte_vld | output | 1 | One-cycle strobe for a payload byte |
| byte_out | output | 8 | Payload byte |
| slot_idx | output | 5 | Slot number of `byte_out` |
| rem_urgent | output | 1 | Urgent remote alarm from the service word |
| rem_minor | output | 1 | Non-urgent remote alarm from the service word |
| nat_bits | output | 4 | National spare bits from the service word |
| svc_x | output | 1 | International bit of the service word |
| fas_x | output | 1 | International bit of the alignment word (double-frame only) |

## Verification
The bench starts the line at a random bit offset. This catches a design that can only lock when the frame is already aligned to its counter, or that misplaces the slot boundary after the hunt. The bench breaks runs of errored alignment words with a correct one, and separately sends a run of three. A design that counts total errors rather than consecutive ones would drop lock too early, and one with an off-by-one threshold would drop it at the wrong frame. A candidate followed by a bad service bit must not lock; a design that skips the service check would lock a frame too early. In unstructured mode the scoreboard expects slot 0 in the lock frame but not in the loss frame, and expects slot 16 to appear. A wrong slot map shows up as missing or extra bytes.

// File: rtl/e1_rx_pkg.sv
package e1_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CHK_SVC = 2'd1,
    ST_CHK_FAS = 2'd2,
    ST_LOCK    = 2'd3
  } sync_state_t;

  // Seven trailing bits of the alignment word (bit 1 is excluded)
  localparam logic [6:0] ALIGN_PATTERN = 7'b0011011;

endpackage

// File: rtl/e1_bit_tracker.sv
module e1_bit_tracker #(
  parameter int SLOT_BITS  = 8,
  parameter int FRAME_BITS = 256,
  localparam int CW = $clog2(FRAME_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_en,
  input  logic                 bit_in,
  input  logic                 align_load,
  output logic [SLOT_BITS-1:0] sr_next,
  output logic [CW-1:0]        cnt
);

  logic [SLOT_BITS-1:0] sr_q;

  // Byte window including the bit arriving in this cycle
  assign sr_next = {sr_q[SLOT_BITS-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
      cnt  <= '0;
    end else if (bit_en) begin
      sr_q <= sr_next;
      if (align_load)
        cnt <= CW'(SLOT_BITS);          // next bit opens slot 1
      else if (cnt == CW'(FRAME_BITS - 1))
        cnt <= '0;
      else
        cnt <= cnt + 1'b1;
    end
  end

  // R5: frame position wraps to zero after the last bit of slot 31
  p_cnt_wrap_r5 : assert property (@(posedge clk) disable iff (rst)
    (bit_en && !align_load && cnt == CW'(FRAME_BITS - 1)) |=> (cnt == '0));

  // R2: a hunt match places the counter at the first bit of slot 1
  p_load_pos_r2 : assert property (@(posedge clk) disable iff (rst)
    (bit_en && align_load) |=> (cnt == CW'(SLOT_BITS)));

endmodule

// File: rtl/e1_frame_sync.sv
module e1_frame_sync
  import e1_rx_pkg::*;
#(
  parameter int SLOT_BITS  = 8,
  parameter int FRAME_BITS = 256,
  parameter int LOSS_COUNT = 3,
  localparam int CW = $clog2(FRAME_BITS),
  localparam int EW = $clog2(LOSS_COUNT + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_en,
  input  logic [SLOT_BITS-1:0] sr_next,
  input  logic [CW-1:0]        cnt,
  input  logic                 mode_crc4,
  output logic                 align_load,
  output logic                 lock_next,
  output logic                 locked,
  output logic                 rem_urgent,
  output logic                 rem_minor,
  output logic [3:0]           nat_bits,
  output logic                 svc_x,
  output logic                 fas_x
);

  sync_state_t   state_q, state_n;
  logic [EW-1:0] err_q, err_n;
  logic          exp_fas_q, exp_fas_n;
  logic          take_svc, take_fas;
  logic          fas_hit, svc_ok, slot0_end;

  // Bit 1 of the byte is sr_next[7]; bits 2..8 are sr_next[6:0]
  assign fas_hit   = (sr_next[6:0] == ALIGN_PATTERN);
  assign svc_ok    = sr_next[6];
  assign slot0_end = bit_en && (cnt == CW'(SLOT_BITS - 1));

  always_comb begin
    state_n    = state_q;
    err_n      = err_q;
    exp_fas_n  = exp_fas_q;
    align_load = 1'b0;
    take_svc   = 1'b0;
    take_fas   = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (bit_en && fas_hit) begin
          state_n    = ST_CHK_SVC;
          align_load = 1'b1;
        end
      end
      ST_CHK_SVC: begin
        if (slot0_end) begin
          if (svc_ok) begin
            state_n  = ST_CHK_FAS;
            take_svc = 1'b1;
          end else begin
            state_n = ST_HUNT;
          end
        end
      end
      ST_CHK_FAS: begin
        if (slot0_end) begin
          if (fas_hit) begin
            state_n   = ST_LOCK;
            exp_fas_n = 1'b0;
            err_n     = '0;
            take_fas  = 1'b1;
          end else begin
            state_n = ST_HUNT;
          end
        end
      end
      ST_LOCK: begin
        if (slot0_end) begin
          exp_fas_n = !exp_fas_q;
          if (exp_fas_q) begin
            if (fas_hit) begin
              err_n    = '0;
              take_fas = 1'b1;
            end else if (err_q == EW'(LOSS_COUNT - 1)) begin
              err_n   = '0;
              state_n = ST_HUNT;
            end else begin
              err_n = err_q + 1'b1;
            end
          end else if (svc_ok) begin
            take_svc = 1'b1;
          end
        end
      end
      default: state_n = ST_HUNT;
    endcase
  end

  assign lock_next = (state_n == ST_LOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_HUNT;
      err_q     <= '0;
      exp_fas_q <= 1'b0;
      locked    <= 1'b0;
    end else begin
      state_q   <= state_n;
      err_q     <= err_n;
      exp_fas_q <= exp_fas_n;
      locked    <= lock_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_urgent <= 1'b0;
      rem_minor  <= 1'b0;
      nat_bits   <= '0;
      svc_x      <= 1'b0;
      fas_x      <= 1'b0;
    end else begin
      if (take_svc) begin
        svc_x      <= sr_next[7];
        rem_urgent <= sr_next[5];
        rem_minor  <= sr_next[4];
        nat_bits   <= sr_next[3:0];
      end
      if (take_fas)
        fas_x <= mode_crc4 ? 1'b0 : sr_next[7];
    end
  end

  logic in_lock;
  assign in_lock = (state_q == ST_LOCK);

  // R2: lock is entered only from the final alignment check
  p_lock_entry_r2 : assert property (@(posedge clk) disable iff (rst)
    $rose(in_lock) |-> ($past(state_q) == ST_CHK_FAS));

  // R4: the error run never reaches the loss threshold while held
  p_err_bound_r4 : assert property (@(posedge clk) disable iff (rst)
    err_q < EW'(LOSS_COUNT));

  // R3: a failed service check always returns to the search
  p_svc_fail_r3 : assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHK_SVC && slot0_end && !svc_ok) |=> (state_q == ST_HUNT));

  // R8: alarm and spare outputs hold unless a service word is taken
  p_svc_hold_r8 : assert property (@(posedge clk) disable iff (rst)
    !take_svc |=> $stable({rem_urgent, rem_minor, nat_bits, svc_x}));

  // R9: CRC4 mode never reports the check bit
  p_fas_x_crc4_r9 : assert property (@(posedge clk) disable iff (rst)
    (take_fas && mode_crc4) |=> !fas_x);

endmodule

// File: rtl/e1_payload_out.sv
module e1_payload_out #(
  parameter int SLOTS      = 32,
  parameter int SLOT_BITS  = 8,
  parameter int SIG_SLOT   = 16,
  localparam int FRAME_BITS = SLOTS * SLOT_BITS,
  localparam int CW  = $clog2(FRAME_BITS),
  localparam int SBW = $clog2(SLOT_BITS),
  localparam int SW  = CW - SBW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_en,
  input  logic [CW-1:0]        cnt,
  input  logic [SLOT_BITS-1:0] sr_next,
  input  logic                 lock_next,
  input  logic                 mode_unstruct,
  output logic                 pay_vld,
  output logic [SLOT_BITS-1:0] pay_byte,
  output logic [SW-1:0]        pay_slot
);

  logic [SLOTS-1:0] struct_map;
  logic [SW-1:0]    cur_slot;
  logic             slot_end, carried;

  // Structured map: every slot except alignment slot 0 and signalling slot
  for (genvar g = 0; g < SLOTS; g++) begin : g_map
    assign struct_map[g] = (g != 0) && (g != SIG_SLOT);
  end

  assign cur_slot = cnt[CW-1:SBW];
  assign slot_end = bit_en && (cnt[SBW-1:0] == SBW'(SLOT_BITS - 1));
  assign carried  = mode_unstruct || struct_map[cur_slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      pay_vld  <= 1'b0;
      pay_byte <= '0;
      pay_slot <= '0;
    end else begin
      pay_vld <= slot_end && carried && lock_next;
      if (slot_end && carried && lock_next) begin
        pay_byte <= sr_next;
        pay_slot <= cur_slot;
      end
    end
  end

  // R5: structured mode never delivers slot 0 or the signalling slot
  p_struct_map_r5 : assert property (@(posedge clk) disable iff (rst)
    (pay_vld && !$past(mode_unstruct)) |->
      (pay_slot != SW'(0) && pay_slot != SW'(SIG_SLOT)));

endmodule

// File: rtl/e1_rx_aligner.sv
module e1_rx_aligner #(
  parameter int SLOTS      = 32,
  parameter int SLOT_BITS  = 8,
  parameter int SIG_SLOT   = 16,
  parameter int LOSS_COUNT = 3,
  localparam int FRAME_BITS = SLOTS * SLOT_BITS,
  localparam int CW = $clog2(FRAME_BITS),
  localparam int SW = $clog2(SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_en,
  input  logic                 bit_in,
  input  logic                 mode_unstruct,
  input  logic                 mode_crc4,
  output logic                 locked,
  output logic                 byte_vld,
  output logic [SLOT_BITS-1:0] byte_out,
  output logic [SW-1:0]        slot_idx,
  output logic                 rem_urgent,
  output logic                 rem_minor,
  output logic [3:0]           nat_bits,
  output logic                 svc_x,
  output logic                 fas_x
);

  logic [SLOT_BITS-1:0] sr_next;
  logic [CW-1:0]        cnt;
  logic                 align_load;
  logic                 lock_next;

  e1_bit_tracker #(
    .SLOT_BITS (SLOT_BITS),
    .FRAME_BITS(FRAME_BITS)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .align_load(align_load),
    .sr_next   (sr_next),
    .cnt       (cnt)
  );

  e1_frame_sync #(
    .SLOT_BITS (SLOT_BITS),
    .FRAME_BITS(FRAME_BITS),
    .LOSS_COUNT(LOSS_COUNT)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .sr_next   (sr_next),
    .cnt       (cnt),
    .mode_crc4 (mode_crc4),
    .align_load(align_load),
    .lock_next (lock_next),
    .locked    (locked),
    .rem_urgent(rem_urgent),
    .rem_minor (rem_minor),
    .nat_bits  (nat_bits),
    .svc_x     (svc_x),
    .fas_x     (fas_x)
  );

  e1_payload_out #(
    .SLOTS    (SLOTS),
    .SLOT_BITS(SLOT_BITS),
    .SIG_SLOT (SIG_SLOT)
  ) u_pay (
    .clk          (clk),
    .rst          (rst),
    .bit_en       (bit_en),
    .cnt          (cnt),
    .sr_next      (sr_next),
    .lock_next    (lock_next),
    .mode_unstruct(mode_unstruct),
    .pay_vld      (byte_vld),
    .pay_byte     (byte_out),
    .pay_slot     (slot_idx)
  );

  // R7: payload strobes only appear while lock is held
  p_vld_locked_r7 : assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> locked);

endmodule

// File: tb/test_e1_rx_aligner.sv
module test_e1_rx_aligner;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0, bit_in = 1'b0;
  logic       mode_unstruct = 1'b0, mode_crc4 = 1'b0;
  logic       locked, byte_vld, rem_urgent, rem_minor, svc_x, fas_x;
  logic [7:0] byte_out;
  logic [4:0] slot_idx;
  logic [3:0] nat_bits;

  int checks = 0;
  int fails  = 0;
  int frame_no = 0;
  logic [12:0] expq[$];

  always #5 clk = ~clk;

  e1_rx_aligner i_e1_rx_aligner (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .mode_unstruct(mode_unstruct), .mode_crc4(mode_crc4),
    .locked(locked), .byte_vld(byte_vld), .byte_out(byte_out),
    .slot_idx(slot_idx), .rem_urgent(rem_urgent), .rem_minor(rem_minor),
    .nat_bits(nat_bits), .svc_x(svc_x), .fas_x(fas_x)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && byte_vld) begin
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 unexpected byte actual=%0h/%0d expected=none", byte_out, slot_idx);
      end else begin
        logic [12:0] e;
        e = expq.pop_front();
        chk(mode_unstruct ? "R6 payload" : "R5 payload", {slot_idx, byte_out}, e);
      end
    end
  end

  function automatic logic [7:0] fas_w(input logic x, input bit bad);
    return bad ? {x, 7'b0011111} : {x, 7'b0011011};
  endfunction

  function automatic logic [7:0] svc_w(input logic x, input logic b2, input logic d,
                                       input logic n, input logic [3:0] y);
    return {x, b2, d, n, y};
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] s0, input bit out0, input bit outrest, input bit ones);
    for (int s = 0; s < 32; s++) begin
      logic [7:0] v;
      bit carried, want;
      v = (s == 0) ? s0 : (ones ? 8'hFF : 8'((frame_no * 53 + s * 29 + 7) ^ 8'h5A));
      carried = mode_unstruct || (s != 0 && s != 16);
      want = (s == 0) ? out0 : outrest;
      if (carried && want) expq.push_back({5'(s), v});
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
    end
    frame_no++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 locked", locked, 0);
    chk("R1 byte_vld", byte_vld, 0);
    chk("R1 alarms", {rem_urgent, rem_minor, nat_bits, svc_x, fas_x}, 0);

    // Structured, double-frame, random offset of idle ones
    begin
      int n;
      n = $urandom_range(1, 255);
      for (int i = 0; i < n; i++) send_bit(1'b1);
    end
    send_frame(fas_w(1, 0), 0, 0, 0);                     // f0 candidate
    send_frame(svc_w(1, 1, 1, 0, 4'hA), 0, 0, 0);         // f1 service check
    chk("R2 not yet locked", locked, 0);
    chk("R8 capture in check", {svc_x, rem_urgent, rem_minor, nat_bits}, {1'b1, 1'b1, 1'b0, 4'hA});
    send_frame(fas_w(0, 0), 1, 1, 0);                     // f2 lock frame
    chk("R2 locked", locked, 1);
    chk("R9 fas_x double-frame 0", fas_x, 0);
    send_frame(svc_w(0, 1, 0, 1, 4'h5), 1, 1, 0);         // f3
    chk("R8 capture locked", {svc_x, rem_urgent, rem_minor, nat_bits}, {1'b0, 1'b0, 1'b1, 4'h5});
    send_frame(fas_w(1, 0), 1, 1, 0);                     // f4
    chk("R9 fas_x double-frame 1", fas_x, 1);
    send_frame(svc_w(1, 0, 1, 0, 4'hF), 1, 1, 0);         // f5 bit2=0
    chk("R8 hold on bad service", {svc_x, rem_urgent, rem_minor, nat_bits}, {1'b0, 1'b0, 1'b1, 4'h5});

    // Error runs that must not drop lock
    send_frame(fas_w(1, 1), 1, 1, 0);                     // f6 err 1
    send_frame(svc_w(0, 1, 0, 0, 4'h1), 1, 1, 0);
    send_frame(fas_w(1, 1), 1, 1, 0);                     // f8 err 2
    chk("R4 two errors keep lock", locked, 1);
    send_frame(svc_w(0, 1, 0, 0, 4'h2), 1, 1, 0);
    send_frame(fas_w(1, 0), 1, 1, 0);                     // f10 good, run reset
    send_frame(svc_w(0, 1, 0, 0, 4'h3), 1, 1, 0);
    send_frame(fas_w(1, 1), 1, 1, 0);                     // f12 err 1
    send_frame(svc_w(0, 1, 0, 0, 4'h4), 1, 1, 0);
    send_frame(fas_w(1, 1), 1, 1, 0);                     // f14 err 2
    chk("R4 interrupted run keeps lock", locked, 1);
    send_frame(svc_w(1, 1, 1, 1, 4'h6), 1, 1, 0);
    send_frame(fas_w(1, 1), 0, 0, 1);                     // f16 err 3: loss
    chk("R4 loss after three", locked, 0);
    chk("R8 values before loss", {svc_x, rem_urgent, rem_minor, nat_bits}, {1'b1, 1'b1, 1'b1, 4'h6});

    // Unstructured, CRC4; a candidate rejected by its service word
    mode_unstruct = 1'b1;
    mode_crc4     = 1'b1;
    send_frame(svc_w(1, 1, 1, 1, 4'h0), 0, 0, 1);         // f17 hunting
    chk("R7 no lock while hunting", locked, 0);
    send_frame(fas_w(1, 0), 0, 0, 1);                     // f18 candidate
    send_frame(svc_w(1, 0, 1, 1, 4'hF), 0, 0, 1);         // f19 bad service
    chk("R3 rejected candidate", locked, 0);
    send_frame(fas_w(1, 0), 0, 0, 1);                     // f20 new candidate
    chk("R3 no lock on third frame of rejected", locked, 0);
    send_frame(svc_w(0, 1, 1, 0, 4'h3), 0, 0, 0);         // f21
    send_frame(fas_w(1, 0), 1, 1, 0);                     // f22 lock, slot 0 out
    chk("R2 relock", locked, 1);
    chk("R9 fas_x crc4 cleared", fas_x, 0);
    chk("R8 capture after relock", {svc_x, rem_urgent, rem_minor, nat_bits}, {1'b0, 1'b1, 1'b0, 4'h3});
    send_frame(svc_w(1, 1, 0, 0, 4'h9), 1, 1, 0);         // f23
    send_frame(fas_w(0, 0), 1, 1, 0);                     // f24
    chk("R6 still locked", locked, 1);

    repeat (10) @(negedge clk);
    chk("R5 R6 all expected bytes seen", 32'(expq.size()), 0);
    finish_run();
  end

endmodule